// File: doc/BRIEF.md
# Parallel Control-Register Port with Auto-Incrementing Pointer

This block sits between an 8-bit microprocessor bus and a bank of write-only configuration registers. The bus side has a data input, a chip select (active low), a read/not-write line, a one-bit port select and an active-low data acknowledge. The port select chooses between two ports. One is the pointer port, which holds the number of the register to be written next. The other is the data port, which writes into the register that the pointer names. After every data-port access the pointer moves on by one. This lets software load a run of registers with one pointer write followed by a burst of data writes.

The configuration registers cannot be read back over the bus. The only bus read returns a status byte supplied by the surrounding chip, and it is fetched by reading the pointer port. The chip core reads the register contents through a separate registered lookup port. A synchronous reset abandons any bus cycle in progress and returns the pointer to zero. It loads three registers with fixed values and leaves every other register as it was. The tri-state pads are outside the block, so the data and acknowledge outputs each come with their own output enable.

Top module: `pcif_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dtack_oe` and `dout_oe` are low, `dtack_n` is high and `dout` is 00h.
- R2: A write (`rw`=0) with `rsel`=0 loads `din` into the pointer. The next data write lands at that address.
- R3: A write with `rsel`=1 stores `din` in the register the pointer names, and the pointer then advances by one.
- R4: The pointer wraps from FFh to 00h when it advances.
- R5: A read (`rw`=1) with `rsel`=0 drives the `status` byte on `dout` with `dout_oe` high for the duration of the acknowledge, and it leaves the pointer unchanged.
- R6: A read with `rsel`=1 drives no data (`dout_oe` stays low) and changes no register, but it still advances the pointer.
- R7: If `cs_n` is sampled low at clock edge k, `dtack_n` goes low and `dtack_oe` goes high after edge k+1. If `cs_n` is sampled high at edge m, both are released after edge m+1. `dtack_oe` is high only during an acknowledge.
- R8: Each assertion of `cs_n` performs exactly one operation, however many cycles it is held low.
- R9: Reset sets register 3Ah to 00h, register 61h to 15h and register 6Ch to 00h. All other registers keep their contents.
- R10: A cycle that is open when reset arrives is abandoned. It is never acknowledged and performs nothing until `cs_n` has gone high again. Reset also clears the pointer to 00h.
- R11: `cfg_rdata` shows the register selected by `cfg_raddr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 1 | 0 = pointer port, 1 = data port |
| din | input | 8 | Bus data into the block |
| dout | output | 8 | Bus data out of the block (status byte) |
| dout_oe | output | 1 | Output enable for `dout` |
| dtack_n | output | 1 | Data acknowledge, active low |
| dtack_oe | output | 1 | Output enable for `dtack_n` |
| status | input | 8 | Status byte returned on pointer-port reads |
| cfg_raddr | input | 8 | Core-side register lookup address |
| cfg_rdata | output | 8 | Core-side register contents, one cycle later |

## Verification
The bench uses the default 8-bit pointer and 8-bit data widths. With these values, one burst of 256 data writes covers every register, and the pointer passes the FFh-to-00h wrap. The lookup port then reads back the whole bank against a value computed from each address. This sweep takes in the three preset addresses, both before and after a reset that arrives in the middle of an open bus cycle.

// File: rtl/pcif_pkg.sv
package pcif_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_HOLD = 2'd2
  } bus_state_t;
endpackage

// File: rtl/pcif_bus_fsm.sv
// Bus-side sequencer: samples the bus, runs one operation per select,
// owns the pointer and produces a registered write strobe.
module pcif_bus_fsm
  import pcif_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          rsel,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          dtack_n,
  output logic          dtack_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam logic [AW-1:0] PTR_STEP = AW'(1);

  logic          cs_s, rw_s, rsel_s;
  logic [DW-1:0] din_s;
  bus_state_t    st;
  logic [AW-1:0] ptr;

  // Input sampling stage, deliberately not reset so the first
  // post-reset cycle sees the real select level.
  always_ff @(posedge clk) begin
    cs_s   <= cs_n;
    rw_s   <= rw;
    rsel_s <= rsel;
    din_s  <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HOLD;
      ptr      <= '0;
      dout     <= '0;
      dout_oe  <= 1'b0;
      dtack_n  <= 1'b1;
      dtack_oe <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!cs_s) begin
            st       <= ST_ACK;
            dtack_n  <= 1'b0;
            dtack_oe <= 1'b1;
            if (!rw_s && !rsel_s) begin
              ptr <= AW'(din_s);
            end else if (!rw_s && rsel_s) begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= din_s;
              ptr     <= ptr + PTR_STEP;
            end else if (rw_s && !rsel_s) begin
              dout    <= status;
              dout_oe <= 1'b1;
            end else begin
              ptr <= ptr + PTR_STEP;
            end
          end
        end
        ST_ACK: begin
          if (cs_s) begin
            st       <= ST_IDLE;
            dtack_n  <= 1'b1;
            dtack_oe <= 1'b0;
            dout_oe  <= 1'b0;
            dout     <= '0;
          end
        end
        default: begin
          if (cs_s) st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pcif_regfile.sv
// Register bank: a plain RAM for the bulk, plus small reset-loaded
// flops for the preset addresses, overriding the RAM on readout.
module pcif_regfile #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int PRESET_N = 3,
  parameter logic [PRESET_N*AW-1:0] PRESET_ADDR = '0,
  parameter logic [PRESET_N*DW-1:0] PRESET_VAL  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic [DW-1:0] pre_reg [PRESET_N];
  logic [DW-1:0] pre_q   [PRESET_N];
  logic [PRESET_N-1:0] hit_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
  end

  for (genvar i = 0; i < PRESET_N; i++) begin : g_preset
    localparam logic [AW-1:0] P_ADDR = PRESET_ADDR[i*AW +: AW];
    localparam logic [DW-1:0] P_VAL  = PRESET_VAL[i*DW +: DW];
    always_ff @(posedge clk) begin
      if (rst) pre_reg[i] <= P_VAL;
      else if (wr_en && wr_addr == P_ADDR) pre_reg[i] <= wr_data;
    end
    always_ff @(posedge clk) begin
      hit_q[i] <= (rd_addr == P_ADDR);
      pre_q[i] <= pre_reg[i];
    end
  end

  always_comb begin
    rd_data = mem_q;
    for (int i = 0; i < PRESET_N; i++) begin
      if (hit_q[i]) rd_data = pre_q[i];
    end
  end
endmodule

// File: rtl/pcif_ctrl.sv
module pcif_ctrl #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int PRESET_N = 3,
  parameter logic [PRESET_N*AW-1:0] PRESET_ADDR = {8'h6C, 8'h61, 8'h3A},
  parameter logic [PRESET_N*DW-1:0] PRESET_VAL  = {8'h00, 8'h15, 8'h00}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          rsel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          dtack_n,
  output logic          dtack_oe,
  input  logic [DW-1:0] status,
  input  logic [AW-1:0] cfg_raddr,
  output logic [DW-1:0] cfg_rdata
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  pcif_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .rsel(rsel), .din(din),
    .status(status), .dout(dout), .dout_oe(dout_oe), .dtack_n(dtack_n),
    .dtack_oe(dtack_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  pcif_regfile #(
    .AW(AW), .DW(DW), .PRESET_N(PRESET_N),
    .PRESET_ADDR(PRESET_ADDR), .PRESET_VAL(PRESET_VAL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(cfg_raddr), .rd_data(cfg_rdata)
  );
endmodule

// File: rtl/pcif_ctrl_chk.sv
module pcif_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic [DW-1:0] status,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          dtack_n,
  input logic          dtack_oe
);
  // R1: outputs idle right after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dtack_oe && !dout_oe && dtack_n));

  // R7: acknowledge begins two edges after a low select sample
  p_ack_after_select_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> ($past(cs_n, 2) == 1'b0));

  // R7: a high select sample releases the acknowledge two edges later
  p_release_after_deselect_r7: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 2) |-> !dtack_oe);

  // R5: read data is only driven while acknowledging
  p_dout_within_ack_r5: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> (!dtack_n && dtack_oe));

  // R5: driven byte is the status seen when the read was taken
  p_dout_is_status_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> (dout == $past(status)));

  // R8: acknowledge holds while select stays low
  p_ack_held_r8: assert property (@(posedge clk) disable iff (rst)
    (dtack_oe && !cs_n) |=> dtack_oe);
endmodule

bind pcif_ctrl pcif_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .status(status), .dout(dout),
  .dout_oe(dout_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe)
);

// File: tb/pcif_ctrl_bench.sv
module pcif_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       rw = 1'b0;
  logic       rsel = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] status = '0;
  logic [7:0] cfg_raddr = '0;
  logic [7:0] dout, cfg_rdata;
  logic       dout_oe, dtack_n, dtack_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  pcif_ctrl u_pcif_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .rsel(rsel), .din(din),
    .dout(dout), .dout_oe(dout_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe),
    .status(status), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic r, input logic s, input logic [7:0] d,
                           input int hold, output logic [7:0] seen,
                           output logic seen_oe);
    @(negedge clk);
    rw = r; rsel = s; din = d; cs_n = 1'b0;
    @(negedge clk);
    chk(dtack_oe == 1'b0 && dtack_n == 1'b1, "R7 no ack one edge after select", dtack_oe, 0);
    @(negedge clk);
    chk(dtack_oe == 1'b1 && dtack_n == 1'b0, "R7 ack two edges after select", dtack_oe, 1);
    seen = dout; seen_oe = dout_oe;
    for (int i = 0; i < hold; i++) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(dtack_oe == 1'b1, "R7 ack held one edge after deselect", dtack_oe, 1);
    @(negedge clk);
    chk(dtack_oe == 1'b0 && dtack_n == 1'b1 && dout_oe == 1'b0,
        "R7 release after deselect", dtack_oe, 0);
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    cfg_raddr = a;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  initial begin
    logic [7:0] sv, rv;
    logic so;
    int bad;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(dtack_oe == 0 && dout_oe == 0 && dtack_n == 1 && dout == 0, "R1 during reset", dtack_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dtack_oe == 0 && dout_oe == 0 && dtack_n == 1 && dout == 0, "R1 after reset", dout, 0);

    // R2/R3/R4: pointer to 00, burst of 256 writes, then one more wraps
    bus_cycle(1'b0, 1'b0, 8'h00, 0, sv, so);
    for (int a = 0; a < 256; a++) begin
      bus_cycle(1'b0, 1'b1, pat(a), a % 3, sv, so);
      model[a] = pat(a);
    end
    bus_cycle(1'b0, 1'b1, 8'hAA, 0, sv, so);
    model[0] = 8'hAA;
    bad = 0;
    for (int a = 0; a < 256; a++) begin
      cfg_read(8'(a), rv);
      if (rv != model[a]) begin
        bad++;
        chk(1'b0, $sformatf("R3 burst readback addr %0h", a), rv, model[a]);
      end
    end
    chk(bad == 0, "R3 R11 full bank sweep", bad, 0);
    cfg_read(8'h00, rv);
    chk(rv == 8'hAA, "R4 pointer wrapped to 00", rv, 8'hAA);

    // R2: pointer load then data write
    bus_cycle(1'b0, 1'b0, 8'h80, 0, sv, so);
    bus_cycle(1'b0, 1'b1, 8'h5C, 0, sv, so);
    model[8'h80] = 8'h5C;
    cfg_read(8'h80, rv);
    chk(rv == 8'h5C, "R2 write at loaded pointer", rv, 8'h5C);
    cfg_read(8'h81, rv);
    chk(rv == model[8'h81], "R2 neighbour untouched", rv, model[8'h81]);

    // R5: status read via pointer port; pointer stays at 81
    status = 8'hC3;
    bus_cycle(1'b1, 1'b0, 8'h00, 2, sv, so);
    chk(so == 1'b1 && sv == 8'hC3, "R5 status on dout", sv, 8'hC3);
    bus_cycle(1'b0, 1'b1, 8'h11, 0, sv, so);
    model[8'h81] = 8'h11;
    cfg_read(8'h81, rv);
    chk(rv == 8'h11, "R5 pointer unchanged by status read", rv, 8'h11);

    // R6: data-port read drives nothing, writes nothing, advances
    bus_cycle(1'b1, 1'b1, 8'hEE, 0, sv, so);
    chk(so == 1'b0, "R6 no data driven", so, 0);
    bus_cycle(1'b0, 1'b1, 8'h22, 0, sv, so);
    model[8'h83] = 8'h22;
    cfg_read(8'h82, rv);
    chk(rv == model[8'h82], "R6 skipped register unchanged", rv, model[8'h82]);
    cfg_read(8'h83, rv);
    chk(rv == 8'h22, "R6 pointer advanced by data read", rv, 8'h22);

    // R8: long select performs a single write
    bus_cycle(1'b0, 1'b1, 8'h33, 12, sv, so);
    model[8'h84] = 8'h33;
    cfg_read(8'h84, rv);
    chk(rv == 8'h33, "R8 held write stored", rv, 8'h33);
    cfg_read(8'h85, rv);
    chk(rv == model[8'h85], "R8 only one operation", rv, model[8'h85]);

    // R10: reset during open cycle
    @(negedge clk);
    rw = 1'b0; rsel = 1'b1; din = 8'h44; cs_n = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (dtack_oe) bad++;
    end
    chk(bad == 0, "R10 open cycle not acknowledged", bad, 0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    cfg_read(8'h85, rv);
    chk(rv == model[8'h85], "R10 abandoned write not stored", rv, model[8'h85]);

    // R9: presets loaded, others kept
    model[8'h3A] = 8'h00; model[8'h61] = 8'h15; model[8'h6C] = 8'h00;
    cfg_read(8'h3A, rv);
    chk(rv == 8'h00, "R9 preset 3A", rv, 8'h00);
    cfg_read(8'h61, rv);
    chk(rv == 8'h15, "R9 preset 61", rv, 8'h15);
    cfg_read(8'h6C, rv);
    chk(rv == 8'h00, "R9 preset 6C", rv, 8'h00);
    bad = 0;
    for (int a = 0; a < 256; a++) begin
      cfg_read(8'(a), rv);
      if (rv != model[a]) begin
        bad++;
        chk(1'b0, $sformatf("R9 kept addr %0h", a), rv, model[a]);
      end
    end
    chk(bad == 0, "R9 others kept across reset", bad, 0);

    // R10: pointer cleared by reset
    bus_cycle(1'b0, 1'b1, 8'h66, 0, sv, so);
    cfg_read(8'h00, rv);
    chk(rv == 8'h66, "R10 pointer back at 00", rv, 8'h66);

    // R11: lookup latency of one edge
    @(negedge clk);
    cfg_raddr = 8'h61;
    @(negedge clk);
    cfg_raddr = 8'h80;
    chk(cfg_rdata == 8'h15, "R11 one-edge lookup", cfg_rdata, 8'h15);
    @(negedge clk);
    chk(cfg_rdata == 8'h5C, "R11 follows new address", cfg_rdata, 8'h5C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule